// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block derives the serial bit clock and the left/right frame clock for an audio serial port from the master clock it runs on. In master mode it divides the master clock by 2 or 4 to form one bit slot. It counts 32, 64 or 128 bit slots per frame and toggles the frame clock at the end of each half. The serializer that sits beside it receives two strobes: one on the first master-clock cycle of every bit slot, and one on the first slot of every frame half. If a frame half holds more slots than the sample word, the bit clock stays at its idle level through the surplus slots, unless gating is switched off.

In slave mode the bit clock and frame clock pins simply follow two external clock inputs. The strobes are then taken from the launch edges of those external clocks after a two-stage synchronizer. A three-state controller sequences the block. `ST_IDLE` is held while `enable` is low, and the configuration inputs are captured in this state. The `start` transition leaves `ST_IDLE` for `ST_MASTER` or `ST_SLAVE`, chosen by the captured mode bit. The `stop` transition returns from either running state to `ST_IDLE` once `enable` falls.

Top module: `audclk_gen`

## Requirements
- R1: While `enable` is low (state `ST_IDLE`), `bclk` equals the captured `bclk_inv`, `lrclk` equals the captured `lrclk_inv`, and both strobes are 0. Every master run starts at slot 0 of the left half.
- R2: In master mode, `div_sel` = 0 gives a bit slot of 2 master-clock cycles and `div_sel` = 1 gives 4 cycles. The un-inverted bit clock is low in the first half of the slot and high in the second half.
- R3: `frame_sel` 0, 1, 2 and 3 give frames of 32, 64, 128 and 128 slots. Each half lasts half the frame. The un-inverted frame clock is low in the first half after start, and it changes on the first cycle of each new half.
- R4: `word_sel` 0, 1, 2 and 3 select word lengths of 16, 24, 32 and 32 slots. A slot whose index within the half is at or above the word length holds `bclk` at its idle level, unless `gate_off` is 1.
- R5: `bclk` is the un-inverted bit clock XOR the captured `bclk_inv`. With `bclk_inv` = 0, data launches on the falling edge.
- R6: `lrclk` is the un-inverted frame clock XOR the captured `lrclk_inv`.
- R7: In master mode, `bit_stb` is high for the first master-clock cycle of every slot, gated slots included. `half_stb` is high only in that same cycle for slot 0 of each half.
- R8: The configuration inputs are captured only while in `ST_IDLE` with `enable` low. Any change made while running has no effect until the next start.
- R9: In slave mode, `bclk` and `lrclk` follow `ext_bclk` and `ext_lrclk` directly. `bit_stb` pulses once for each launch edge of `ext_bclk`: falling when `bclk_inv` = 0, rising when 1. `half_stb` pulses once for each change of `ext_lrclk`. Both are detected after a two-stage synchronizer.
- R10: Under reset, `bclk`, `lrclk`, `bit_stb` and `half_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; also clocks all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global run control |
| div_sel | input | 1 | Bit slot length: 0 = 2 cycles, 1 = 4 cycles |
| frame_sel | input | 2 | Frame length in slots: 32/64/128/128 |
| word_sel | input | 2 | Word length: 16/24/32/32 slots |
| bclk_inv | input | 1 | Bit clock polarity |
| lrclk_inv | input | 1 | Frame clock polarity |
| master_mode | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| gate_off | input | 1 | 1 = never suppress bit clock pulses |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_lrclk | input | 1 | External frame clock (slave mode) |
| bclk | output | 1 | Bit clock pin |
| lrclk | output | 1 | Frame clock pin |
| bit_stb | output | 1 | Slot start strobe |
| half_stb | output | 1 | Half-frame start strobe |

## Verification
At every half boundary, three events fall in the same master-clock cycle: the frame clock toggles, `half_stb` rises, and a new `bit_stb` fires. The slot counter wraps in that cycle as well. The bench sweeps every divide ratio, frame length, word length, gating setting and polarity pair, and runs two full frames for each combination. It predicts every output cycle by cycle from the cycle index since start, so a coincidence that is one cycle late, or a gate that opens one slot late at the wrap, shows up as a mismatch. While each run is in progress the bench drives every configuration input to a different value, so any leak of a live setting also appears in that same prediction.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MASTER = 2'd1,
        ST_SLAVE  = 2'd2
    } mode_state_e;

    typedef struct packed {
        logic       div4;
        logic [1:0] frame_sel;
        logic [1:0] word_sel;
        logic       bclk_inv;
        logic       lr_inv;
        logic       master;
        logic       no_gate;
    } clk_cfg_t;

    // Slots in one frame half.
    function automatic int unsigned half_len(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 16;
            2'd1:    return 32;
            default: return 64;
        endcase
    endfunction

    // Slots that carry sample bits.
    function automatic int unsigned word_len(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 16;
            2'd1:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/bitclk_divider.sv
module bitclk_divider #(
    parameter int DIV_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div4,
    output logic slot_start,
    output logic slot_end,
    output logic raw_high
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;
    logic [DIV_W-1:0] mid;

    assign last = div4 ? DIV_W'(3) : DIV_W'(1);
    assign mid  = div4 ? DIV_W'(2) : DIV_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign slot_start = run && (cnt_q == '0);
    assign slot_end   = run && (cnt_q == last);
    assign raw_high   = run && (cnt_q >= mid);
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer #(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              slot_end,
    input  logic [SLOT_W-1:0] half_last,
    input  logic [SLOT_W:0]   word_slots,
    output logic              lr_raw,
    output logic              slot_active,
    output logic              first_slot
);
    logic [SLOT_W-1:0] slot_q;
    logic              lr_q;
    logic              wrap;

    assign wrap = slot_end && (slot_q == half_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            lr_q   <= 1'b0;
        end else if (!run) begin
            slot_q <= '0;
            lr_q   <= 1'b0;
        end else if (wrap) begin
            slot_q <= '0;
            lr_q   <= ~lr_q;
        end else if (slot_end) begin
            slot_q <= slot_q + SLOT_W'(1);
        end
    end

    assign lr_raw      = lr_q;
    assign slot_active = ({1'b0, slot_q} < word_slots);
    assign first_slot  = (slot_q == '0);
endmodule

// File: rtl/slave_edge_detect.sv
module slave_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_bclk,
    input  logic ext_lrclk,
    input  logic launch_rise,
    output logic bit_edge,
    output logic lr_edge
);
    logic [1:0] ext_in;
    logic [1:0] cur;
    logic [1:0] prev;

    assign ext_in = {ext_lrclk, ext_bclk};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        logic [STAGES:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-1:0], ext_in[g]};
        end
        assign cur[g]  = sh_q[STAGES-1];
        assign prev[g] = sh_q[STAGES];
    end

    assign bit_edge = launch_rise ? (cur[0] & ~prev[0]) : (~cur[0] & prev[0]);
    assign lr_edge  = cur[1] ^ prev[1];
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
    import audclk_pkg::*;
#(
    parameter int DIV_W       = 2,
    parameter int SLOT_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       div_sel,
    input  logic [1:0] frame_sel,
    input  logic [1:0] word_sel,
    input  logic       bclk_inv,
    input  logic       lrclk_inv,
    input  logic       master_mode,
    input  logic       gate_off,
    input  logic       ext_bclk,
    input  logic       ext_lrclk,
    output logic       bclk,
    output logic       lrclk,
    output logic       bit_stb,
    output logic       half_stb
);
    localparam int LEN_W = SLOT_W + 1;

    mode_state_e state_q, state_d;
    clk_cfg_t    cfg_q, cfg_in;

    logic              master_run;
    logic              slot_start, slot_end, raw_high;
    logic              lr_raw, slot_active, first_slot;
    logic              s_bit_edge, s_lr_edge;
    logic [LEN_W-1:0]  half_slots, word_slots;
    logic [SLOT_W-1:0] half_last;

    assign cfg_in = '{div4:      div_sel,
                      frame_sel: frame_sel,
                      word_sel:  word_sel,
                      bclk_inv:  bclk_inv,
                      lr_inv:    lrclk_inv,
                      master:    master_mode,
                      no_gate:   gate_off};

    // configuration capture, idle only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cfg_q <= '0;
        else if (state_q == ST_IDLE && !enable) cfg_q <= cfg_in;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start (idle -> master/slave), stop (running -> idle)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (enable)  state_d = cfg_q.master ? ST_MASTER : ST_SLAVE;
            ST_MASTER: if (!enable) state_d = ST_IDLE;
            ST_SLAVE:  if (!enable) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    assign master_run = (state_q == ST_MASTER);
    assign half_slots = LEN_W'(half_len(cfg_q.frame_sel));
    assign word_slots = LEN_W'(word_len(cfg_q.word_sel));
    assign half_last  = half_slots[SLOT_W-1:0] - SLOT_W'(1);

    bitclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (master_run),
        .div4       (cfg_q.div4),
        .slot_start (slot_start),
        .slot_end   (slot_end),
        .raw_high   (raw_high)
    );

    frame_sequencer #(.SLOT_W(SLOT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (master_run),
        .slot_end    (slot_end),
        .half_last   (half_last),
        .word_slots  (word_slots),
        .lr_raw      (lr_raw),
        .slot_active (slot_active),
        .first_slot  (first_slot)
    );

    slave_edge_detect #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_bclk    (ext_bclk),
        .ext_lrclk   (ext_lrclk),
        .launch_rise (cfg_q.bclk_inv),
        .bit_edge    (s_bit_edge),
        .lr_edge     (s_lr_edge)
    );

    // outputs per state
    always_comb begin
        unique case (state_q)
            ST_MASTER: begin
                bclk     = (raw_high & (slot_active | cfg_q.no_gate)) ^ cfg_q.bclk_inv;
                lrclk    = lr_raw ^ cfg_q.lr_inv;
                bit_stb  = slot_start;
                half_stb = slot_start & first_slot;
            end
            ST_SLAVE: begin
                bclk     = ext_bclk;
                lrclk    = ext_lrclk;
                bit_stb  = s_bit_edge;
                half_stb = s_lr_edge;
            end
            default: begin
                bclk     = cfg_q.bclk_inv;
                lrclk    = cfg_q.lr_inv;
                bit_stb  = 1'b0;
                half_stb = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk
    import audclk_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic        bclk,
    input logic        lrclk,
    input logic        bit_stb,
    input logic        half_stb,
    input mode_state_e state_q,
    input clk_cfg_t    cfg_q
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bit_stb && !half_stb)); // R1

    AST_BIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MASTER && bit_stb) |=> !bit_stb); // R2

    AST_LR_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MASTER && $past(state_q) == ST_MASTER && lrclk != $past(lrclk))
        |-> half_stb); // R3

    AST_SLOT_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MASTER && bit_stb) |-> (bclk == cfg_q.bclk_inv)); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(cfg_q)); // R8
endmodule

bind audclk_gen audclk_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .bclk     (bclk),
    .lrclk    (lrclk),
    .bit_stb  (bit_stb),
    .half_stb (half_stb),
    .state_q  (state_q),
    .cfg_q    (cfg_q)
);

// File: tb/audclk_gen_bench.sv
module audclk_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       div_sel = 1'b0;
    logic [1:0] frame_sel = '0;
    logic [1:0] word_sel = '0;
    logic       bclk_inv = 1'b0;
    logic       lrclk_inv = 1'b0;
    logic       master_mode = 1'b0;
    logic       gate_off = 1'b0;
    logic       ext_bclk = 1'b0;
    logic       ext_lrclk = 1'b0;
    logic       bclk, lrclk, bit_stb, half_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit count_en = 1'b0;
    int n_bit = 0;
    int n_half = 0;

    always #2 clk = ~clk;

    audclk_gen u_audclk_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
        .frame_sel(frame_sel), .word_sel(word_sel), .bclk_inv(bclk_inv),
        .lrclk_inv(lrclk_inv), .master_mode(master_mode), .gate_off(gate_off),
        .ext_bclk(ext_bclk), .ext_lrclk(ext_lrclk),
        .bclk(bclk), .lrclk(lrclk), .bit_stb(bit_stb), .half_stb(half_stb)
    );

    always @(negedge clk) if (count_en) begin
        n_bit  += int'(bit_stb);
        n_half += int'(half_stb);
    end

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_master(input int d, input int f, input int w,
                              input int g, input int bi, input int li);
        int div, half, wl, len;
        div  = d ? 4 : 2;
        half = (f == 0) ? 16 : (f == 1) ? 32 : 64;
        wl   = (w == 0) ? 16 : (w == 1) ? 24 : 32;
        len  = 2 * div * 2 * half + 2;
        @(negedge clk);
        enable = 1'b0; div_sel = d[0]; frame_sel = f[1:0]; word_sel = w[1:0];
        gate_off = g[0]; bclk_inv = bi[0]; lrclk_inv = li[0]; master_mode = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        // R8: scramble every setting while running
        div_sel = ~d[0]; frame_sel = f[1:0] ^ 2'd1; word_sel = w[1:0] ^ 2'd1;
        gate_off = ~g[0]; bclk_inv = ~bi[0]; lrclk_inv = ~li[0]; master_mode = 1'b0;
        for (int i = 0; i < len; i++) begin
            int dd, slot, hf, act, eb, el, es, eh;
            @(negedge clk);
            dd   = i % div;
            slot = (i / div) % half;
            hf   = (i / (div * half)) % 2;
            act  = (g != 0 || slot < wl) ? 1 : 0;
            eb   = (((dd >= div / 2) ? 1 : 0) & act) ^ bi;
            el   = hf ^ li;
            es   = (dd == 0) ? 1 : 0;
            eh   = (es == 1 && slot == 0) ? 1 : 0;
            check(int'(bclk),     eb, "R2 R4 R5 R8 bclk");
            check(int'(lrclk),    el, "R3 R6 R8 lrclk");
            check(int'(bit_stb),  es, "R7 bit_stb");
            check(int'(half_stb), eh, "R7 half_stb");
        end
        enable = 1'b0;
        @(negedge clk);
        check(int'(bclk),     bi, "R1 idle bclk");
        check(int'(lrclk),    li, "R1 idle lrclk");
        check(int'(bit_stb),  0,  "R1 idle bit_stb");
        check(int'(half_stb), 0,  "R1 idle half_stb");
    endtask

    task automatic run_slave(input int bi);
        @(negedge clk);
        enable = 1'b0; master_mode = 1'b0; bclk_inv = bi[0];
        ext_bclk = 1'b0; ext_lrclk = 1'b0;
        @(negedge clk);
        enable = 1'b1; master_mode = 1'b1;   // ignored while running (R8)
        n_bit = 0; n_half = 0; count_en = 1'b1;
        for (int p = 0; p < 64; p++) begin
            ext_bclk = 1'b1;
            repeat (4) @(negedge clk);
            check(int'(bclk), 1, "R9 slave bclk follow");
            check(int'(lrclk), int'(ext_lrclk), "R9 slave lrclk follow");
            ext_bclk = 1'b0;
            if (p % 16 == 15) ext_lrclk = ~ext_lrclk;
            repeat (4) @(negedge clk);
            check(int'(bclk), 0, "R9 slave bclk follow");
        end
        repeat (6) @(negedge clk);
        count_en = 1'b0;
        check(n_bit, 64, "R9 slave bit_stb count");
        check(n_half, 4, "R9 slave half_stb count");
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(int'(bclk),     0, "R10 reset bclk");
        check(int'(lrclk),    0, "R10 reset lrclk");
        check(int'(bit_stb),  0, "R10 reset bit_stb");
        check(int'(half_stb), 0, "R10 reset half_stb");
        rst_n = 1'b1;
        for (int d = 0; d < 2; d++)
            for (int f = 0; f < 3; f++)
                for (int w = 0; w < 3; w++)
                    for (int g = 0; g < 2; g++)
                        for (int p = 0; p < 4; p++)
                            run_master(d, f, w, g, p % 2, p / 2);
        // R3 R4: top code values of the frame and word fields
        run_master(1, 3, 3, 0, 0, 0);
        run_master(0, 3, 3, 1, 1, 1);
        run_slave(0);
        run_slave(1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule